// File: doc/BRIEF.md
# Object Virtual Address Generator

This block forms the two-part virtual address for each memory access made by a stack processor with object-based memory. The first part is a 16-bit object number and the second is a 16-bit field number. The caller names the kind of access: an instruction fetch, a data access through register A, a data access through register R, or a block-copy access through the return stack. The block then picks the matching object and field sources.

For instruction fetches, the object number is a masked copy of the self register. When self bit 15 is clear, that copy is zero. When bit 15 is set, self bits 14:13 decide how many of the upper bits survive. This lets the software make groups of objects share code.

The block also computes a physical address in the object table. The table holds four header words per object, so an object's entry starts at its ID times four. Header words 0 and 1 hold the high and low halves of the physical base address of the rest of the object. A field number of 4 or more lies outside the header. Such a field is flagged for indirection, and the table address then points at header word 0. All outputs are registered and appear one cycle after the request.

Top module: `objva_gen`

## Requirements
- R1: The field number is taken from `pc` for kind 0 (fetch), from `reg_a` for kind 1, and from `reg_r` for kinds 2 and 3.
- R2: For kinds 1 and 2, the object number equals `self_reg`.
- R3: For kind 3 (return-stack block copy), the object number equals `rtop_hi`, the high word of the return stack top.
- R4: For kind 0, when `self_reg[15]` is 0, the object number is 0.
- R5: For kind 0, when `self_reg[15]` is 1, the object number is `self_reg` ANDed with a mask chosen by `self_reg[14:13]`: 00 gives 16'hE000, 01 gives 16'hF800, 10 gives 16'hFF00, 11 gives 16'hFFFF.
- R6: `tbl_addr` equals object×4 plus `field[1:0]` when the field is below 4. It equals object×4 when the field is 4 or more. Bits 31:18 are always 0.
- R7: `indirect` is 1 exactly when the field number is 4 or more.
- R8: `va_valid` follows `req_valid` one cycle later. In a cycle without a request, `va_obj`, `va_field`, `tbl_addr` and `indirect` keep their values.
- R9: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_kind | input | 2 | 0 fetch, 1 data via A, 2 data via R, 3 return-stack block |
| self_reg | input | 16 | Self register |
| reg_a | input | 16 | Register A |
| reg_r | input | 16 | Register R (low word of return stack top) |
| rtop_hi | input | 16 | High word of return stack top |
| pc | input | 16 | Program counter |
| va_valid | output | 1 | Registered address valid |
| va_obj | output | 16 | Object number |
| va_field | output | 16 | Field number |
| tbl_addr | output | 32 | Object-table physical address |
| indirect | output | 1 | Field lies beyond the four header words |

## Verification
A wrong object source or a wrong fetch mask shows up as a wrong `va_obj` one cycle after the request. A wrong entry in the mask selection appears only when self bit 15 is set and bits 14:13 take that value, so the stimulus steps through all four cases. A slip in the table arithmetic appears in `tbl_addr` on the same cycle. Fields near the boundary value 4 expose any error in the indirection flag. A failure to hold the outputs appears on the first idle cycle after a request.

// File: rtl/objva_gen.sv
module objva_gen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [1:0]   req_kind,
  input  logic [W-1:0] self_reg,
  input  logic [W-1:0] reg_a,
  input  logic [W-1:0] reg_r,
  input  logic [W-1:0] rtop_hi,
  input  logic [W-1:0] pc,
  output logic         va_valid,
  output logic [W-1:0] va_obj,
  output logic [W-1:0] va_field,
  output logic [31:0]  tbl_addr,
  output logic         indirect
);
  localparam int TW = W + 2;

  logic [W-1:0] fetch_mask, obj_n, field_n;
  logic         ind_n;
  logic [TW-1:0] tbl_n;

  always_comb begin
    if (!self_reg[W-1]) fetch_mask = '0;
    else begin
      case (self_reg[W-2:W-3])
        2'b00:   fetch_mask = {{3{1'b1}}, {(W-3){1'b0}}};
        2'b01:   fetch_mask = {{5{1'b1}}, {(W-5){1'b0}}};
        2'b10:   fetch_mask = {{8{1'b1}}, {(W-8){1'b0}}};
        default: fetch_mask = '1;
      endcase
    end
  end

  always_comb begin
    case (req_kind)
      2'd0:    begin obj_n = self_reg & fetch_mask; field_n = pc;    end
      2'd1:    begin obj_n = self_reg;              field_n = reg_a; end
      2'd2:    begin obj_n = self_reg;              field_n = reg_r; end
      default: begin obj_n = rtop_hi;               field_n = reg_r; end
    endcase
  end

  assign ind_n = |field_n[W-1:2];
  assign tbl_n = {obj_n, ind_n ? 2'b00 : field_n[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_valid <= 1'b0;
      va_obj   <= '0;
      va_field <= '0;
      tbl_addr <= '0;
      indirect <= 1'b0;
    end else begin
      va_valid <= req_valid;
      if (req_valid) begin
        va_obj   <= obj_n;
        va_field <= field_n;
        tbl_addr <= {{(32-TW){1'b0}}, tbl_n};
        indirect <= ind_n;
      end
    end
  end
endmodule

module objva_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_kind,
  input logic [15:0] self_reg,
  input logic [15:0] rtop_hi,
  input logic        va_valid,
  input logic [15:0] va_obj,
  input logic [15:0] va_field,
  input logic [31:0] tbl_addr,
  input logic        indirect
);
  a_r3_rtop_object: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == 2'd3 |=> va_obj == $past(rtop_hi));
  a_r4_integer_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == 2'd0 && !self_reg[15] |=> va_obj == 16'h0);
  a_r6_table_range: assert property (@(posedge clk) disable iff (!rst_n)
    va_valid |-> tbl_addr[31:18] == 14'h0 && tbl_addr[17:2] == va_obj);
  a_r7_indirect_flag: assert property (@(posedge clk) disable iff (!rst_n)
    va_valid |-> indirect == (va_field >= 16'd4));
  a_r8_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> va_valid);
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !va_valid && $stable(va_obj) && $stable(va_field) && $stable(tbl_addr));
endmodule

bind objva_gen objva_gen_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .self_reg(self_reg), .rtop_hi(rtop_hi), .va_valid(va_valid), .va_obj(va_obj),
  .va_field(va_field), .tbl_addr(tbl_addr), .indirect(indirect)
);

// File: tb/test_objva_gen.sv
`timescale 1ns/1ps
module test_objva_gen;
  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [1:0] req_kind = 0;
  logic [15:0] self_reg = 0, reg_a = 0, reg_r = 0, rtop_hi = 0, pc = 0;
  logic va_valid, indirect;
  logic [15:0] va_obj, va_field;
  logic [31:0] tbl_addr;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  objva_gen i_objva_gen (.*);

  logic        e_valid = 0, e_ind = 0;
  logic [15:0] e_obj = 0, e_field = 0;
  longint      e_tbl = 0;
  string       obj_tag = "R9";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid <= 0; e_obj <= 0; e_field <= 0; e_tbl <= 0; e_ind <= 0; obj_tag <= "R9";
    end else begin
      e_valid <= req_valid;
      if (req_valid) begin
        int o, f, m;
        string t;
        case (req_kind)
          0: begin
            f = pc;
            if (!self_reg[15]) begin o = 0; t = "R4"; end
            else begin
              case (self_reg[14:13])
                0: m = 'hE000; 1: m = 'hF800; 2: m = 'hFF00; default: m = 'hFFFF;
              endcase
              o = self_reg & m; t = "R5";
            end
          end
          1: begin f = reg_a; o = self_reg; t = "R2"; end
          2: begin f = reg_r; o = self_reg; t = "R2"; end
          default: begin f = reg_r; o = rtop_hi; t = "R3"; end
        endcase
        e_obj <= 16'(o); e_field <= 16'(f); e_ind <= (f >= 4);
        e_tbl <= longint'(o) * 4 + ((f >= 4) ? 0 : (f % 4));
        obj_tag <= t;
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    chk(rst_n ? "R8 valid" : "R9 valid", va_valid, e_valid);
    chk(obj_tag, va_obj, e_obj);
    chk(rst_n ? "R1" : "R9 field", va_field, e_field);
    chk(rst_n ? "R6" : "R9 table", tbl_addr, e_tbl);
    chk(rst_n ? "R7" : "R9 flag", indirect, e_ind);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic step(bit v, int k, int s, int a, int r, int h, int p);
    @(negedge clk);
    compare_all();
    cyc++;
    req_valid = v; req_kind = 2'(k); self_reg = 16'(s);
    reg_a = 16'(a); reg_r = 16'(r); rtop_hi = 16'(h); pc = 16'(p);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) begin @(negedge clk); compare_all(); end // R9 reset state
    rst_n = 1;
    // R4 integer fetch, R5 all four masks, R6/R7 field boundary
    step(1, 0, 'h7ABC, 0, 0, 0, 'h0003);
    step(1, 0, 'h9FFF, 0, 0, 0, 'h0004);
    step(1, 0, 'hBFFF, 0, 0, 0, 'h0002);
    step(1, 0, 'hDFFF, 0, 0, 0, 'h1234);
    step(1, 0, 'hFFFF, 0, 0, 0, 'h0001);
    // R2 data accesses, R3 return-stack block
    step(1, 1, 'h1357, 'h0000, 'h55, 'h66, 'h77);
    step(1, 2, 'h2468, 'h11, 'h0005, 'h66, 'h77);
    step(1, 3, 'h2468, 'h11, 'h0002, 'hFFFF, 'h77);
    // R8 hold while idle with changing inputs
    step(0, 0, 'h0000, 'h1, 'h2, 'h3, 'h4);
    step(0, 3, 'hFFFF, 'hAAAA, 'hBBBB, 'hCCCC, 'hDDDD);
    step(1, 3, 'h0001, 0, 'hFFFF, 'h8000, 0);
    for (int i = 0; i < 600; i++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 3), $urandom, $urandom_range(0, 7),
           ($urandom % 2) ? $urandom_range(0, 6) : $urandom, $urandom, $urandom);
    step(0, 0, 0, 0, 0, 0, 0);
    // R9 reset clears outputs mid-run
    step(1, 1, 'hFFFF, 'h3, 0, 0, 0);
    @(negedge clk); compare_all();
    rst_n = 0;
    @(negedge clk); compare_all();
    finish_run();
  end
endmodule